// File: doc/BRIEF.md
# Address-less I2C Light-Sensor Target

This block is the serial bus target of an ambient-light converter. It samples the SCL and SDA wires with the system clock and finds START and STOP conditions. It compares a 7-bit address whose three low bits come from strap pins and acknowledges the bytes meant for it. The device has no register pointer. A write carries exactly one meaningful byte, the command, which the conversion logic receives together with a one-cycle strobe. A read streams a fixed little-endian sequence taken from the latched conversion result and the latched integration counter.

The conversion logic reports through `ext_timing` whether the externally timed modes are active. When they are, a read yields four bytes; otherwise it yields only the two result bytes, and the target lets go of SDA after that. Any command with its top bit set, other than the power-down code 0x8C, selects a loop-back test, in which every read byte carries the last command written. The target never stretches the clock, and it drives SDA only low, through an open-drain enable.

Top module: `lux_i2c_target`

## Requirements
- R1: The target answers to the 7-bit address formed by binary 1000 in bits 6..3 and `addr_sel[2:0]` in bits 2..0, sent MSB first with the R/W bit last (1 = read). It drives SDA low in the ninth clock of a matching address byte. After an address that does not match, it leaves SDA released for every following byte until the next START.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A repeated START without a STOP restarts address reception from its first bit.
- R3: In a write, the first data byte is acknowledged, appears on `cmd_byte` and raises `cmd_strobe` for exactly one clock cycle. Later data bytes of the same write are acknowledged and change neither `cmd_byte` nor the strobe.
- R4: A write consisting of only the address, ended by STOP or by a repeated START, raises `cmd_strobe` once and leaves `cmd_byte` unchanged, so the previous command runs again.
- R5: With `ext_timing` = 1, a read returns four bytes MSB first: result[7:0], result[15:8], counter[7:0], counter[15:8].
- R6: With `ext_timing` = 0, a read returns only result[7:0] and result[15:8]. The target releases SDA after the second byte even when the master acknowledges it, so any further byte reads as 0xFF.
- R7: All read bytes and the stream length are captured when the read address is matched. Changes to `result_in`, `counter_in` or `ext_timing` during the read do not alter that read, and the next read returns the new values.
- R8: When `cmd_byte[7]` = 1 and `cmd_byte` is not 0x8C, every byte of a read equals `cmd_byte`, and the length still follows R5/R6. After the command 0x8C, reads return the sensor bytes.
- R9: A master NACK (SDA high in the ninth clock of a read byte) ends the stream: the target keeps SDA released until the next START.
- R10: After reset, `sda_drive_low` = 0, `cmd_byte` = 0x00 and `cmd_strobe` = 0.
- R11: `sda_drive_low` changes only while the synchronized SCL is low, except that it releases at a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Sampled SCL wire level |
| sda_in | input | 1 | Sampled SDA wire level |
| addr_sel | input | 3 | Strap pins giving the low three address bits |
| result_in | input | 16 | Latched conversion result |
| counter_in | input | 16 | Latched integration counter value |
| ext_timing | input | 1 | 1 = externally timed mode, four-byte reads |
| sda_drive_low | output | 1 | Open-drain enable; 1 pulls SDA low |
| cmd_byte | output | 8 | Current command register |
| cmd_strobe | output | 1 | One-cycle pulse that starts execution of `cmd_byte` |

## Verification
On every cycle the assertions check that the SDA enable changes only while SCL is low, that the command register moves only together with its strobe and that the strobe lasts one cycle, that the byte index never passes the captured stream length, that SDA is released whenever the engine ignores the bus, and that the captured read bytes hold between captures. Only the bench scenarios can show the address decode against the strap pins, the byte order and length of each read, the loop-back substitution, the snapshot's immunity to input changes during a transfer, and the re-execution on an address-only write. Each of these depends on a complete bus sequence rather than on a single cycle.

// File: rtl/lux_i2c_pkg.sv
package lux_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK
  } bus_state_t;

  localparam logic [7:0] CMD_POWER_DOWN = 8'h8C;

  // loop-back test: top bit set, but not the power-down code
  function automatic logic is_echo_cmd(input logic [7:0] c);
    return c[7] && (c != CMD_POWER_DOWN);
  endfunction

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  localparam int N = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [N-1:0] scl_q, sda_q;
  logic         scl_d, sda_d;

  // idle bus is high, so the chains reset to ones
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[N-2:0], scl_in};
      sda_q <= {sda_q[N-2:0], sda_in};
      scl_d <= scl_q[N-1];
      sda_d <= sda_q[N-1];
    end
  end

  assign scl_lvl   = scl_q[N-1];
  assign sda_lvl   = sda_q[N-1];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  assign start_evt = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/lux_read_snapshot.sv
module lux_read_snapshot
  import lux_i2c_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = $clog2(2 * (DATA_W / 8))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [DATA_W-1:0] result_in,
  input  logic [DATA_W-1:0] counter_in,
  input  logic [7:0]        cmd_in,
  input  logic              ext_timing,
  input  logic [IDX_W-1:0]  idx,
  output logic [7:0]        byte_out,
  output logic [IDX_W-1:0]  last_idx
);

  localparam int FIELD_BYTES = DATA_W / 8;
  localparam int TOTAL       = 2 * FIELD_BYTES;

  logic [TOTAL-1:0][7:0] snap;
  logic [TOTAL-1:0][7:0] live;
  logic                  echo;

  assign echo = is_echo_cmd(cmd_in);

  // byte slots: result bytes first, then counter bytes, little-endian
  for (genvar k = 0; k < TOTAL; k++) begin : g_slot
    if (k < FIELD_BYTES) begin : g_res
      assign live[k] = echo ? cmd_in : result_in[8*k +: 8];
    end else begin : g_cnt
      assign live[k] = echo ? cmd_in : counter_in[8*(k-FIELD_BYTES) +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap     <= '0;
      last_idx <= IDX_W'(FIELD_BYTES - 1);
    end else if (capture) begin
      snap     <= live;
      last_idx <= ext_timing ? IDX_W'(TOTAL - 1) : IDX_W'(FIELD_BYTES - 1);
    end
  end

  assign byte_out = snap[idx];

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(snap) && $stable(last_idx)); // R7

endmodule

// File: rtl/lux_i2c_target.sv
module lux_i2c_target
  import lux_i2c_pkg::*;
#(
  parameter logic [3:0] ADDR_HI     = 4'b1000,
  parameter int         DATA_W      = 16,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [2:0]        addr_sel,
  input  logic [DATA_W-1:0] result_in,
  input  logic [DATA_W-1:0] counter_in,
  input  logic              ext_timing,
  output logic              sda_drive_low,
  output logic [7:0]        cmd_byte,
  output logic              cmd_strobe
);

  localparam int IDX_W = $clog2(2 * (DATA_W / 8));

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;

  i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_lines (
    .clk      (clk),
    .rst      (rst),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt)
  );

  bus_state_t       state;
  logic [3:0]       bitcnt;
  logic [7:0]       sh;
  logic             rw;
  logic             addr_w_open;   // write address acked, no data byte yet
  logic             more;          // another byte follows the current one
  logic             mnack;
  logic             capture;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] last_idx;
  logic [7:0]       rd_byte;
  logic [7:0]       cmd_q;
  logic             strobe_q;
  logic             drive_q;
  logic             addr_hit;

  lux_read_snapshot #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_snap (
    .clk       (clk),
    .rst       (rst),
    .capture   (capture),
    .result_in (result_in),
    .counter_in(counter_in),
    .cmd_in    (cmd_q),
    .ext_timing(ext_timing),
    .idx       (idx),
    .byte_out  (rd_byte),
    .last_idx  (last_idx)
  );

  assign addr_hit = (sh[7:1] == {ADDR_HI, addr_sel});

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      bitcnt      <= '0;
      sh          <= '0;
      rw          <= 1'b0;
      addr_w_open <= 1'b0;
      more        <= 1'b0;
      mnack       <= 1'b0;
      capture     <= 1'b0;
      idx         <= '0;
      cmd_q       <= 8'h00;
      strobe_q    <= 1'b0;
      drive_q     <= 1'b0;
    end else begin
      strobe_q <= 1'b0;
      capture  <= 1'b0;
      if (start_evt || stop_evt) begin
        // address-only write: run the stored command again
        if (addr_w_open) strobe_q <= 1'b1;
        addr_w_open <= 1'b0;
        drive_q     <= 1'b0;
        bitcnt      <= '0;
        state       <= start_evt ? ST_ADDR : ST_IDLE;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_ADDR: begin
            if (scl_rise && bitcnt != 4'd8) begin
              sh     <= {sh[6:0], sda_lvl};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (addr_hit) begin
                drive_q <= 1'b1;
                rw      <= sh[0];
                capture <= sh[0];
                idx     <= '0;
                state   <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rw) begin
                sh      <= rd_byte;
                drive_q <= ~rd_byte[7];
                state   <= ST_RD_BYTE;
              end else begin
                drive_q     <= 1'b0;
                addr_w_open <= 1'b1;
                state       <= ST_WR_BYTE;
              end
            end
          end
          ST_WR_BYTE: begin
            if (scl_rise && bitcnt != 4'd8) begin
              sh     <= {sh[6:0], sda_lvl};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              drive_q <= 1'b1;
              state   <= ST_WR_ACK;
              if (addr_w_open) begin
                cmd_q       <= sh;
                strobe_q    <= 1'b1;
                addr_w_open <= 1'b0;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              drive_q <= 1'b0;
              bitcnt  <= '0;
              state   <= ST_WR_BYTE;
            end
          end
          ST_RD_BYTE: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                drive_q <= 1'b0;
                more    <= (idx != last_idx);
                if (idx != last_idx) idx <= idx + 1'b1;
                state   <= ST_RD_ACK;
              end else begin
                sh      <= {sh[6:0], 1'b0};
                drive_q <= ~sh[6];
                bitcnt  <= bitcnt + 4'd1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              mnack <= sda_lvl;
            end else if (scl_fall) begin
              bitcnt <= '0;
              if (!mnack && more) begin
                sh      <= rd_byte;
                drive_q <= ~rd_byte[7];
                state   <= ST_RD_BYTE;
              end else begin
                drive_q <= 1'b0;
                state   <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_drive_low = drive_q;
  assign cmd_byte      = cmd_q;
  assign cmd_strobe    = strobe_q;

  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(drive_q) |-> !scl_lvl); // R11
  AST_RELEASE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    ($fell(drive_q) && !$past(start_evt) && !$past(stop_evt)) |-> !scl_lvl); // R11
  AST_CMD_WITH_STROBE: assert property (@(posedge clk) disable iff (rst)
    !$stable(cmd_q) |-> strobe_q); // R3
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    strobe_q |=> !strobe_q); // R3
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
    idx <= last_idx); // R6
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !drive_q); // R9

endmodule

// File: tb/sim_lux_i2c_target.sv
module sim_lux_i2c_target;

  localparam int Q = 20; // clock cycles per quarter SCL period

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic [2:0]  addr_sel = 3'b100;
  logic [15:0] result_in = 16'h0000;
  logic [15:0] counter_in = 16'h0000;
  logic        ext_timing = 1'b0;
  logic        sda_drive_low;
  logic [7:0]  cmd_byte;
  logic        cmd_strobe;
  logic        sda_bus;

  int unsigned checks = 0;
  int unsigned errors = 0;
  int unsigned strobes = 0;
  logic [7:0]  strobe_cmd = 8'h00;

  always #4 clk = ~clk;

  assign sda_bus = sda_m & ~sda_drive_low;

  lux_i2c_target u0 (
    .clk          (clk),
    .rst          (rst),
    .scl_in       (scl_m),
    .sda_in       (sda_bus),
    .addr_sel     (addr_sel),
    .result_in    (result_in),
    .counter_in   (counter_in),
    .ext_timing   (ext_timing),
    .sda_drive_low(sda_drive_low),
    .cmd_byte     (cmd_byte),
    .cmd_strobe   (cmd_strobe)
  );

  always @(posedge clk) begin
    if (!rst && cmd_strobe) begin
      strobes    = strobes + 1;
      strobe_cmd = cmd_byte;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b;    wq(Q);
    scl_m = 1'b1; wq(2*Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    b = sda_bus;  wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    acked = ~b;
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~ack);
  endtask

  task automatic t_reset;
    check("R10", "drive after reset", 32'(sda_drive_low), 32'd0);
    check("R10", "cmd after reset", 32'(cmd_byte), 32'h00);
    check("R10", "strobes after reset", strobes, 0);
  endtask

  task automatic t_write_cmd;
    logic a;
    int unsigned s0 = strobes;
    bus_start;
    send_byte(8'h88, a); check("R1", "ack of address 0x44 write", 32'(a), 32'd1);
    send_byte(8'h04, a); check("R3", "ack of command byte", 32'(a), 32'd1);
    bus_stop;
    check("R3", "cmd after write", 32'(cmd_byte), 32'h04);
    check("R3", "one strobe", strobes - s0, 1);
    check("R3", "strobed value", 32'(strobe_cmd), 32'h04);
  endtask

  task automatic t_extra_bytes;
    logic a;
    int unsigned s0 = strobes;
    bus_start;
    send_byte(8'h88, a);
    send_byte(8'h30, a);
    send_byte(8'h55, a); check("R3", "extra byte acked", 32'(a), 32'd1);
    bus_stop;
    check("R3", "extra byte not stored", 32'(cmd_byte), 32'h30);
    check("R3", "single strobe for two bytes", strobes - s0, 1);
  endtask

  task automatic t_addr_only;
    logic a;
    int unsigned s0 = strobes;
    bus_start;
    send_byte(8'h88, a); check("R4", "address-only ack", 32'(a), 32'd1);
    bus_stop;
    check("R4", "re-execute strobe", strobes - s0, 1);
    check("R4", "cmd unchanged", 32'(cmd_byte), 32'h30);
  endtask

  task automatic t_wrong_addr;
    logic a;
    int unsigned s0 = strobes;
    bus_start;
    send_byte(8'h8A, a); check("R1", "no ack for 0x45", 32'(a), 32'd0);
    send_byte(8'h00, a); check("R1", "ignored byte not acked", 32'(a), 32'd0);
    bus_stop;
    check("R1", "no strobe when ignored", strobes - s0, 0);
    check("R1", "cmd untouched when ignored", 32'(cmd_byte), 32'h30);
    addr_sel = 3'b101;
    bus_start;
    send_byte(8'h8A, a); check("R1", "ack for 0x45 with pins 101", 32'(a), 32'd1);
    bus_stop;
    addr_sel = 3'b100;
  endtask

  task automatic t_read_ext;
    logic a;
    logic [7:0] v;
    ext_timing = 1'b1; result_in = 16'hA1B2; counter_in = 16'hC3D4;
    bus_start;
    send_byte(8'h89, a); check("R1", "read address ack", 32'(a), 32'd1);
    recv_byte(1'b1, v); check("R5", "byte0 result lo", 32'(v), 32'hB2);
    recv_byte(1'b1, v); check("R5", "byte1 result hi", 32'(v), 32'hA1);
    recv_byte(1'b1, v); check("R5", "byte2 counter lo", 32'(v), 32'hD4);
    recv_byte(1'b0, v); check("R5", "byte3 counter hi", 32'(v), 32'hC3);
    bus_stop;
  endtask

  task automatic t_read_int;
    logic a;
    logic [7:0] v;
    ext_timing = 1'b0; result_in = 16'h5A3C;
    bus_start;
    send_byte(8'h89, a);
    recv_byte(1'b1, v); check("R6", "int byte0", 32'(v), 32'h3C);
    recv_byte(1'b1, v); check("R6", "int byte1", 32'(v), 32'h5A);
    recv_byte(1'b0, v); check("R6", "released after two bytes", 32'(v), 32'hFF);
    bus_stop;
  endtask

  task automatic t_snapshot;
    logic a;
    logic [7:0] v;
    ext_timing = 1'b1; result_in = 16'h1234; counter_in = 16'h5678;
    bus_start;
    send_byte(8'h89, a);
    recv_byte(1'b1, v); check("R7", "snap byte0", 32'(v), 32'h34);
    result_in = 16'hEEEE; counter_in = 16'hDDDD; ext_timing = 1'b0;
    recv_byte(1'b1, v); check("R7", "snap byte1 kept", 32'(v), 32'h12);
    recv_byte(1'b1, v); check("R7", "snap byte2 kept", 32'(v), 32'h78);
    recv_byte(1'b0, v); check("R7", "snap byte3 kept", 32'(v), 32'h56);
    bus_stop;
    bus_start;
    send_byte(8'h89, a);
    recv_byte(1'b0, v); check("R7", "next read sees new value", 32'(v), 32'hEE);
    bus_stop;
  endtask

  task automatic t_nack_early;
    logic a;
    logic [7:0] v;
    ext_timing = 1'b1; result_in = 16'h00F0;
    bus_start;
    send_byte(8'h89, a);
    recv_byte(1'b0, v); check("R9", "first byte before nack", 32'(v), 32'hF0);
    recv_byte(1'b0, v); check("R9", "bus released after nack", 32'(v), 32'hFF);
    bus_stop;
  endtask

  task automatic t_repeated_start;
    logic a;
    int unsigned s0 = strobes;
    bus_start;
    send_byte(8'h8A, a); check("R2", "wrong address before restart", 32'(a), 32'd0);
    bus_start;
    send_byte(8'h88, a); check("R2", "ack after repeated start", 32'(a), 32'd1);
    send_byte(8'h0C, a);
    bus_stop;
    check("R2", "cmd after repeated start", 32'(cmd_byte), 32'h0C);
    bus_start;
    send_byte(8'h88, a);
    bus_start;
    send_byte(8'h8A, a);
    bus_stop;
    check("R4", "strobes incl. address-only before restart", strobes - s0, 2);
  endtask

  task automatic t_echo;
    logic a;
    logic [7:0] v;
    bus_start;
    send_byte(8'h88, a);
    send_byte(8'h9A, a);
    bus_stop;
    ext_timing = 1'b0; result_in = 16'h4321;
    bus_start;
    send_byte(8'h89, a);
    recv_byte(1'b1, v); check("R8", "echo byte0", 32'(v), 32'h9A);
    recv_byte(1'b1, v); check("R8", "echo byte1", 32'(v), 32'h9A);
    recv_byte(1'b0, v); check("R8", "echo length follows mode", 32'(v), 32'hFF);
    bus_stop;
    bus_start;
    send_byte(8'h88, a);
    send_byte(8'h8C, a);
    bus_stop;
    ext_timing = 1'b1;
    bus_start;
    send_byte(8'h89, a);
    recv_byte(1'b1, v); check("R8", "power-down not echoed", 32'(v), 32'h21);
    recv_byte(1'b0, v); check("R8", "power-down byte1", 32'(v), 32'h43);
    bus_stop;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R1..: actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wq(5);
    rst = 1'b0;
    wq(5);
    t_reset;
    t_write_cmd;
    t_extra_bytes;
    t_addr_only;
    t_wrong_addr;
    t_read_ext;
    t_read_int;
    t_snapshot;
    t_nack_early;
    t_repeated_start;
    t_echo;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule